// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

A 64-entry translation buffer that instruction fetches and data accesses share. Software fills and maintains it completely. Each entry pairs a tag word with a data word. The tag word gives an effective page number, a 3-bit page-size code and a valid bit. The data word gives a real page number, execute and write permits, a 4-bit zone select and four storage attribute bits. The page-size code belongs to each entry and selects a page from 1 KiB to 16 MiB in steps of four. It sets how many address bits the tag compare skips, and those same bits pass through to the physical address unchanged.

The lookup port takes an address and an access kind. One cycle later it returns a hit flag, the physical address, the zone, the attributes and a permission-fault flag. The software port works on one entry at a time by index. It can read or write either word of that entry, search for the entry that matches an address, drop that matching entry, or drop every entry at once.

Top module: `vpt_tlb`

## Requirements
- R1: After reset every entry is invalid. Lookups miss, and reading any word of any entry returns zero.
- R2: With half select 0, a software access targets the tag word: effective page number in bits 31:10, size code in bits 9:7, valid in bit 6. Bits 5:0 read back as zero.
- R3: With half select 1, a software access targets the data word. A hit returns bits 7:4 of that word on the zone output and bits 3:0 on the attribute output.
- R4: With size code s (0 to 7), address bits below 10+2s take no part in the compare. The physical address is the real page number with those low bits replaced by the lookup address bits.
- R5: Only valid entries can match. When several match, the lowest index wins.
- R6: The lookup result appears with the done flag one cycle after a request. On a miss, the hit, fault, address, zone and attribute outputs are all zero.
- R7: Access kind 0 is a fetch, 1 a load, 2 a store, and 3 behaves as a load. A fetch that hits an entry with data bit 9 clear, or a store that hits an entry with data bit 8 clear, raises the fault flag and still reports the hit.
- R8: Software operation 3 (search) returns, one cycle later, the found flag and the 6-bit index of the winning entry. Both are zero on a miss.
- R9: Software operation 4 clears the valid bit of the winning entry for its address and leaves every other entry unchanged.
- R10: Software operation 5 clears every valid bit.
- R11: A software write (operation 2) is not seen by a lookup issued in the same cycle. It is seen by lookups issued from the next cycle on. Operation 1 is a read, operation 0 is idle, and every non-idle operation pulses the software done flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup effective address |
| lk_kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | 32 | Translated address |
| lk_zone_o | output | 4 | Zone select of the hit entry |
| lk_attr_o | output | 4 | Storage attributes of the hit entry |
| lk_fault_o | output | 1 | Permission fault |
| sw_op_i | input | 3 | Software operation, 0 to 5 |
| sw_idx_i | input | 6 | Entry index for read and write |
| sw_half_i | input | 1 | 0 tag word, 1 data word |
| sw_wdata_i | input | 32 | Write data |
| sw_addr_i | input | 32 | Address for search and drop |
| sw_done_o | output | 1 | Software operation complete |
| sw_rdata_o | output | 32 | Read data |
| sw_found_o | output | 1 | Search found an entry |
| sw_fidx_o | output | 6 | Index found by search |

## Verification
A bad valid bit or tag field shows up on the very next lookup or search that covers that entry. It appears as a wrong hit flag, a wrong winner index, or a translated address whose high bits come from the wrong page. A bad size code shows only at page boundaries. For that reason every size code is driven at the last word inside its page and at the first word past it. A stale permit bit is caught by a fetch or store one cycle later through the fault flag, and a dropped entry is caught by the lookup that follows on the same address.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int unsigned AW          = 32;
  localparam int unsigned PG_LOG_MIN  = 10;
  localparam int unsigned SZ_W        = 3;
  localparam int unsigned EPN_W       = AW - PG_LOG_MIN;
  localparam int unsigned TAG_W       = EPN_W + SZ_W;

  typedef enum logic [2:0] {
    SW_IDLE     = 3'd0,
    SW_READ     = 3'd1,
    SW_WRITE    = 3'd2,
    SW_SEARCH   = 3'd3,
    SW_DROP     = 3'd4,
    SW_DROP_ALL = 3'd5
  } sw_op_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  // ones over the bits that take part in the compare
  function automatic logic [AW-1:0] page_mask(input logic [SZ_W-1:0] sz);
    int unsigned sh;
    sh = PG_LOG_MIN + 2 * int'(sz);
    return ~((AW'(1) << sh) - AW'(1));
  endfunction
endpackage

// File: rtl/vpt_match.sv
module vpt_match #(
  parameter int unsigned N = 64
) (
  input  logic [vpt_pkg::AW-1:0]               addr_i,
  input  logic [N-1:0]                         valid_i,
  input  logic [N-1:0][vpt_pkg::TAG_W-1:0]     tag_i,
  output logic [N-1:0]                         hit_o
);
  localparam int unsigned SZ_W = vpt_pkg::SZ_W;

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [vpt_pkg::AW-1:0] msk;
    logic [vpt_pkg::AW-1:0] base;
    assign msk      = vpt_pkg::page_mask(tag_i[e][SZ_W-1:0]);
    assign base     = {tag_i[e][vpt_pkg::TAG_W-1:SZ_W], {vpt_pkg::PG_LOG_MIN{1'b0}}};
    assign hit_o[e] = valid_i[e] && (((addr_i ^ base) & msk) == '0);
  end
endmodule

// File: rtl/vpt_prio.sv
module vpt_prio #(
  parameter int unsigned N  = 64,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [31:0]      lk_addr_i,
  input  logic [1:0]       lk_kind_i,
  output logic             lk_done_o,
  output logic             lk_hit_o,
  output logic [31:0]      lk_paddr_o,
  output logic [3:0]       lk_zone_o,
  output logic [3:0]       lk_attr_o,
  output logic             lk_fault_o,
  input  logic [2:0]       sw_op_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic             sw_half_i,
  input  logic [31:0]      sw_wdata_i,
  input  logic [31:0]      sw_addr_i,
  output logic             sw_done_o,
  output logic [31:0]      sw_rdata_o,
  output logic             sw_found_o,
  output logic [IDX_W-1:0] sw_fidx_o
);
  import vpt_pkg::*;

  localparam int unsigned EX_BIT = 9;
  localparam int unsigned WR_BIT = 8;
  localparam int unsigned VL_BIT = 6;

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][AW-1:0]    data_q;

  logic [ENTRIES-1:0] lk_match, s_match;
  logic               lk_found, s_found;
  logic [IDX_W-1:0]   lk_idx, s_idx;
  sw_op_e             op;
  logic               unused_wlow;

  assign op          = sw_op_e'(sw_op_i);
  assign unused_wlow = ^sw_wdata_i[VL_BIT-1:0];

  vpt_match #(.N(ENTRIES)) u_lk_match (
    .addr_i(lk_addr_i), .valid_i(valid_q), .tag_i(tag_q), .hit_o(lk_match));
  vpt_prio  #(.N(ENTRIES)) u_lk_prio (
    .req_i(lk_match), .found_o(lk_found), .idx_o(lk_idx));

  vpt_match #(.N(ENTRIES)) u_sw_match (
    .addr_i(sw_addr_i), .valid_i(valid_q), .tag_i(tag_q), .hit_o(s_match));
  vpt_prio  #(.N(ENTRIES)) u_sw_prio (
    .req_i(s_match), .found_o(s_found), .idx_o(s_idx));

  // lookup datapath
  logic [AW-1:0] lk_dw, lk_msk, lk_pa;
  logic          lk_flt;
  always_comb begin
    lk_dw  = data_q[lk_idx];
    lk_msk = page_mask(tag_q[lk_idx][SZ_W-1:0]);
    lk_pa  = (lk_dw & lk_msk) | (lk_addr_i & ~lk_msk);
    lk_flt = (lk_kind_i == ACC_FETCH && !lk_dw[EX_BIT]) ||
             (lk_kind_i == ACC_STORE && !lk_dw[WR_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o  <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_paddr_o <= '0;
      lk_zone_o  <= '0;
      lk_attr_o  <= '0;
      lk_fault_o <= 1'b0;
    end else begin
      lk_done_o <= lk_valid_i;
      if (lk_valid_i && lk_found) begin
        lk_hit_o   <= 1'b1;
        lk_paddr_o <= lk_pa;
        lk_zone_o  <= lk_dw[7:4];
        lk_attr_o  <= lk_dw[3:0];
        lk_fault_o <= lk_flt;
      end else begin
        lk_hit_o   <= 1'b0;
        lk_paddr_o <= '0;
        lk_zone_o  <= '0;
        lk_attr_o  <= '0;
        lk_fault_o <= 1'b0;
      end
    end
  end

  // entry storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
    end else begin
      case (op)
        SW_WRITE: begin
          if (sw_half_i) begin
            data_q[sw_idx_i] <= sw_wdata_i;
          end else begin
            tag_q[sw_idx_i]   <= sw_wdata_i[AW-1:VL_BIT+1];
            valid_q[sw_idx_i] <= sw_wdata_i[VL_BIT];
          end
        end
        SW_DROP:     if (s_found) valid_q[s_idx] <= 1'b0;
        SW_DROP_ALL: valid_q <= '0;
        default: ;
      endcase
    end
  end

  // software response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_done_o  <= 1'b0;
      sw_rdata_o <= '0;
      sw_found_o <= 1'b0;
      sw_fidx_o  <= '0;
    end else begin
      sw_done_o  <= (op != SW_IDLE);
      sw_rdata_o <= '0;
      sw_found_o <= 1'b0;
      sw_fidx_o  <= '0;
      if (op == SW_READ)
        sw_rdata_o <= sw_half_i ? data_q[sw_idx_i]
                                : {tag_q[sw_idx_i], valid_q[sw_idx_i], {VL_BIT{1'b0}}};
      if (op == SW_SEARCH && s_found) begin
        sw_found_o <= 1'b1;
        sw_fidx_o  <= s_idx;
      end
    end
  end

  // assertions
  logic [ENTRIES-1:0] below_s;
  assign below_s = ({{(ENTRIES-1){1'b0}}, 1'b1} << s_idx) - {{(ENTRIES-1){1'b0}}, 1'b1};

  AST_LK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_done_o);  // R6
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0 && lk_zone_o == '0 && lk_attr_o == '0 && !lk_fault_o));  // R6
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o);  // R7
  AST_WINNER_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_found |-> (s_match[s_idx] && (s_match & below_s) == '0));  // R5
  AST_DROP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == SW_DROP && s_found) |=> !valid_q[$past(s_idx)]);  // R9
  AST_DROP_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == SW_DROP_ALL) |=> (valid_q == '0));  // R10
  AST_TAG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == SW_WRITE && !sw_half_i) |=> (valid_q[$past(sw_idx_i)] == $past(sw_wdata_i[VL_BIT])));  // R11
endmodule

// File: tb/vpt_tlb_test.sv
`timescale 1ns/1ps
module vpt_tlb_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        lk_valid_i;
  logic [31:0] lk_addr_i;
  logic [1:0]  lk_kind_i;
  logic        lk_done_o, lk_hit_o, lk_fault_o;
  logic [31:0] lk_paddr_o;
  logic [3:0]  lk_zone_o, lk_attr_o;
  logic [2:0]  sw_op_i;
  logic [5:0]  sw_idx_i;
  logic        sw_half_i;
  logic [31:0] sw_wdata_i, sw_addr_i;
  logic        sw_done_o, sw_found_o;
  logic [31:0] sw_rdata_o;
  logic [5:0]  sw_fidx_o;

  always #2.5 clk = ~clk;

  vpt_tlb uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_kind_i(lk_kind_i),
    .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_paddr_o(lk_paddr_o),
    .lk_zone_o(lk_zone_o), .lk_attr_o(lk_attr_o), .lk_fault_o(lk_fault_o),
    .sw_op_i(sw_op_i), .sw_idx_i(sw_idx_i), .sw_half_i(sw_half_i),
    .sw_wdata_i(sw_wdata_i), .sw_addr_i(sw_addr_i),
    .sw_done_o(sw_done_o), .sw_rdata_o(sw_rdata_o),
    .sw_found_o(sw_found_o), .sw_fidx_o(sw_fidx_o));

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // reference model of the entries
  bit        mv [64];
  bit [24:0] mt [64];
  bit [31:0] md [64];

  function automatic bit [31:0] bmask(input bit [2:0] s);
    return 32'hFFFF_FFFF << (10 + 2 * int'(s));
  endfunction

  function automatic int m_find(input bit [31:0] a);
    for (int i = 0; i < 64; i++)
      if (mv[i] && (((a ^ {mt[i][24:3], 10'b0}) & bmask(mt[i][2:0])) == 0)) return i;
    return -1;
  endfunction

  function automatic bit [31:0] mk_tag(input bit [31:0] va, input bit [2:0] s, input bit v);
    return (va & 32'hFFFF_FC00) | (32'(s) << 7) | (32'(v) << 6);
  endfunction

  function automatic bit [31:0] mk_data(input bit [31:0] pa, input bit ex, input bit wr,
                                        input bit [3:0] zn, input bit [3:0] at);
    return (pa & 32'hFFFF_FC00) | (32'(ex) << 9) | (32'(wr) << 8) | (32'(zn) << 4) | 32'(at);
  endfunction

  typedef struct {
    bit        hit;
    bit        flt;
    bit [31:0] pa;
    bit [3:0]  zn;
    bit [3:0]  at;
    string     rq;
  } exp_t;
  exp_t q[$];

  function automatic exp_t predict(input bit [31:0] a, input int k, input string rq);
    exp_t e;
    int   i;
    e.rq = rq; e.hit = 0; e.flt = 0; e.pa = 0; e.zn = 0; e.at = 0;
    i = m_find(a);
    if (i >= 0) begin
      e.hit = 1;
      e.pa  = (md[i] & bmask(mt[i][2:0])) | (a & ~bmask(mt[i][2:0]));
      e.zn  = md[i][7:4];
      e.at  = md[i][3:0];
      e.flt = (k == 0 && !md[i][9]) || (k == 2 && !md[i][8]);
    end
    return e;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_ni && lk_done_o) begin
      if (q.size() == 0) begin
        chk(0, "R6", "unexpected done", 32'(lk_done_o), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(lk_paddr_o == e.pa, e.rq, "paddr", lk_paddr_o, e.pa);
        chk({lk_hit_o, lk_fault_o, lk_zone_o, lk_attr_o} == {e.hit, e.flt, e.zn, e.at},
            e.rq, "hit/fault/zone/attr",
            32'({lk_hit_o, lk_fault_o, lk_zone_o, lk_attr_o}),
            32'({e.hit, e.flt, e.zn, e.at}));
      end
    end
  end

  task automatic lk(input bit [31:0] a, input int k, input string rq);
    @(negedge clk);
    sw_op_i    = 3'd0;
    lk_valid_i = 1'b1;
    lk_addr_i  = a;
    lk_kind_i  = 2'(k);
    q.push_back(predict(a, k, rq));
  endtask

  task automatic model_apply(input int op, input int idx, input bit half,
                             input bit [31:0] wd, input bit [31:0] a);
    int i;
    case (op)
      2: if (half) md[idx] = wd; else begin mt[idx] = wd[31:7]; mv[idx] = wd[6]; end
      4: begin i = m_find(a); if (i >= 0) mv[i] = 0; end
      5: for (int j = 0; j < 64; j++) mv[j] = 0;
      default: ;
    endcase
  endtask

  task automatic sw_cmd(input int op, input int idx, input bit half,
                        input bit [31:0] wd, input bit [31:0] a, input string rq);
    bit [31:0] e_rd;
    bit        e_fd;
    bit [5:0]  e_ix;
    int        i;
    @(negedge clk);
    lk_valid_i = 1'b0;
    sw_op_i    = 3'(op);
    sw_idx_i   = 6'(idx);
    sw_half_i  = half;
    sw_wdata_i = wd;
    sw_addr_i  = a;
    e_rd = 0; e_fd = 0; e_ix = 0;
    if (op == 1) e_rd = half ? md[idx] : {mt[idx], mv[idx], 6'b0};
    if (op == 3) begin
      i = m_find(a);
      if (i >= 0) begin e_fd = 1; e_ix = 6'(i); end
    end
    model_apply(op, idx, half, wd, a);
    @(negedge clk);
    sw_op_i = 3'd0;
    chk(sw_done_o == 1'b1, rq, "sw done", 32'(sw_done_o), 1);
    chk(sw_rdata_o == e_rd, rq, "sw rdata", sw_rdata_o, e_rd);
    chk({sw_found_o, sw_fidx_o} == {e_fd, e_ix}, rq, "sw found/idx",
        32'({sw_found_o, sw_fidx_o}), 32'({e_fd, e_ix}));
  endtask

  // R11: write and lookup in one cycle, then lookup again
  task automatic write_then_look(input int idx, input bit [31:0] wd, input bit [31:0] a);
    @(negedge clk);
    lk_valid_i = 1'b1; lk_addr_i = a; lk_kind_i = 2'd1;
    sw_op_i = 3'd2; sw_idx_i = 6'(idx); sw_half_i = 1'b1; sw_wdata_i = wd;
    q.push_back(predict(a, 1, "R11 same cycle"));
    model_apply(2, idx, 1'b1, wd, 0);
    @(negedge clk);
    sw_op_i = 3'd0;
    q.push_back(predict(a, 1, "R11 next cycle"));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lk_valid_i = 1'b0;
      sw_op_i    = 3'd0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mv[i] = 0; mt[i] = 0; md[i] = 0; end
    rst_ni = 1'b0; lk_valid_i = 0; lk_addr_i = 0; lk_kind_i = 0;
    sw_op_i = 0; sw_idx_i = 0; sw_half_i = 0; sw_wdata_i = 0; sw_addr_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({lk_done_o, lk_hit_o, sw_done_o} == 3'b000, "R1", "outputs after reset",
        32'({lk_done_o, lk_hit_o, sw_done_o}), 0);
    lk(32'h1000_3000, 1, "R1 lookup after reset");
    sw_cmd(1, 5, 0, 0, 0, "R1 tag after reset");
    sw_cmd(1, 5, 1, 0, 0, "R1 data after reset");

    // fill
    sw_cmd(2, 3,  0, mk_tag(32'h1000_3000, 1, 1), 0, "R2");
    sw_cmd(2, 3,  1, mk_data(32'h8000_5000, 1, 0, 4'd5, 4'hA), 0, "R3");
    sw_cmd(2, 10, 0, mk_tag(32'h2000_0400, 0, 1), 0, "R2");
    sw_cmd(2, 10, 1, mk_data(32'h4000_0C00, 0, 1, 4'd2, 4'h3), 0, "R3");
    sw_cmd(2, 20, 0, mk_tag(32'h34AB_CC00, 7, 1) | 32'h3F, 0, "R2");
    sw_cmd(2, 20, 1, mk_data(32'h7F12_3400, 1, 1, 4'hF, 4'h1), 0, "R3");
    sw_cmd(2, 40, 0, mk_tag(32'h5000_0000, 3, 1), 0, "R5");
    sw_cmd(2, 40, 1, mk_data(32'h6000_0000, 1, 1, 4'd1, 4'h2), 0, "R5");
    sw_cmd(2, 7,  0, mk_tag(32'h5000_0000, 5, 1), 0, "R5");
    sw_cmd(2, 7,  1, mk_data(32'h9000_0000, 1, 1, 4'd7, 4'h4), 0, "R5");
    sw_cmd(2, 41, 0, mk_tag(32'h6000_0000, 0, 0), 0, "R5");
    sw_cmd(2, 41, 1, mk_data(32'h1111_1000, 1, 1, 4'd9, 4'h9), 0, "R5");

    // readback
    sw_cmd(1, 20, 0, 0, 0, "R2 tag readback low bits zero");
    sw_cmd(1, 3,  1, 0, 0, "R3 data readback");

    // lookups, back to back
    lk(32'h1000_3ABC, 1, "R4 4K load");
    lk(32'h1000_3ABC, 2, "R7 store no write permit");
    lk(32'h1000_4000, 1, "R4 past 4K page");
    lk(32'h2000_07FC, 0, "R7 fetch no execute permit");
    lk(32'h2000_07FC, 2, "R7 store permitted");
    lk(32'h2000_0800, 1, "R4 past 1K page");
    lk(32'h34FF_FFFC, 0, "R4 16M ignores tag low bits");
    lk(32'h34FF_FFFC, 3, "R7 kind 3 as load");
    lk(32'h5000_1234, 1, "R5 lowest index wins");
    lk(32'h5001_0000, 1, "R5 only large page covers");
    lk(32'h6000_0000, 1, "R5 invalid entry ignored");
    idle(1);

    // search
    sw_cmd(3, 0, 0, 0, 32'h5000_0010, "R8 search finds lowest");
    sw_cmd(3, 0, 0, 0, 32'h3400_0000, "R8 search 16M page");
    sw_cmd(3, 0, 0, 0, 32'h6000_0000, "R8 search miss");

    // drop one
    sw_cmd(4, 0, 0, 0, 32'h5000_0010, "R9 drop matching entry");
    lk(32'h5000_1234, 1, "R9 next entry takes over");
    lk(32'h1000_3000, 0, "R9 others untouched");
    sw_cmd(1, 7,  0, 0, 0, "R9 dropped tag valid clear");
    sw_cmd(1, 40, 0, 0, 0, "R9 neighbour tag valid kept");

    // write visibility
    write_then_look(3, mk_data(32'hABCD_E000, 1, 1, 4'd6, 4'hC), 32'h1000_3010);
    idle(1);

    // drop all
    sw_cmd(5, 0, 0, 0, 0, "R10 drop all");
    lk(32'h1000_3010, 1, "R10 miss after drop all");
    lk(32'h34AB_CDEF, 1, "R10 miss after drop all");
    sw_cmd(3, 0, 0, 0, 32'h2000_0400, "R10 search miss after drop all");

    // every size code at its page edges
    for (int s = 0; s < 8; s++) begin
      bit [31:0] span;
      span = 32'h1 << (10 + 2 * s);
      sw_cmd(2, 60, 0, mk_tag(32'hC000_0000, 3'(s), 1), 0, "R4");
      sw_cmd(2, 60, 1, mk_data(32'h0155_5400, 1, 1, 4'(s), 4'(s + 1)), 0, "R4");
      lk(32'hC000_0004, 1, "R4 page start");
      lk(32'hC000_0000 | (span - 4), 1, "R4 last word of page");
      lk(32'hC000_0000 | span, 1, "R4 first word past page");
    end
    idle(3);
    chk(q.size() == 0, "R6", "pending results", 32'(q.size()), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule